// File: doc/BRIEF.md
# Zero-Crossing Audio Mute Controller

This block decides when each channel of a stereo digital audio path is muted. It watches the signed left and right sample streams and takes one-cycle configuration writes. Each write carries a general mute request, a mode bit that selects immediate or zero-crossing switching, and an attenuation code for each channel. It drives one mute enable per channel and an active-low flag that goes low when both channels are muted.

In zero-crossing mode a requested change of the general mute state is armed rather than applied. Each channel then flips its own mute switch on that channel's next zero crossing, so the switch avoids an audible step. A very low-frequency or DC-offset signal may never cross zero. To cover that case, software repeats the same write, and any channel still waiting switches at once. A hardware mute pin, active low and synchronized on entry, mutes both channels for as long as it is held. The pin does not disturb the state that the registers request.

Top module: `zc_mute_ctrl`

## Requirements
- R1: After reset both mute outputs are 1, `all_muted_no` is 0, no change is pending, and the held configuration is general mute 1, zero-crossing mode 0, both attenuation codes 0.
- R2: A write (`wr_en_i` high for one cycle) uses `wr_data_i` fields: bit 0 general mute, bit 1 zero-crossing mode, bits 7:2 left attenuation code, bits 13:8 right attenuation code. With bit 1 = 0, both channel switches take the bit 0 value in the cycle after the write.
- R3: With bit 1 = 1, a write whose general mute value differs from a channel's switch only arms that channel. The channel's switch keeps its value until that channel sees a zero crossing, and then takes the armed value in the following cycle.
- R4: A zero crossing is a sample accepted with `smp_valid_i` high that is zero or whose sign bit differs from that of the previous accepted sample on the same channel. Samples presented with `smp_valid_i` low are ignored. The first previous sign after reset is non-negative.
- R5: Left and right detect crossings and switch independently, so one channel may switch while the other is still armed.
- R6: A write whose data equals the held configuration exactly, made while at least one channel is armed, switches every channel to the written general mute value in the next cycle and clears all armed states.
- R7: A zero-crossing-mode write whose general mute value equals a channel's current switch state clears that channel's armed state. A later crossing then leaves the switch unchanged.
- R8: While `hw_mute_ni` is low, both mute outputs are 1. The pin passes through a two-stage synchronizer, so the outputs react at the second rising edge after the pin changes.
- R9: The pin is not stored. Register writes and switching continue while it is held. When it returns high, the outputs again show the register-requested state.
- R10: `all_muted_no` is 0 exactly when both mute outputs are 1.
- R11: An attenuation code above 55 (codes 56 to 63) mutes its channel in the cycle after the write, in either mode. Codes 0 to 55 add no mute.
- R12: When a write and a zero crossing fall in the same cycle, the write decides the switch. The crossing in that cycle does not complete the newly armed change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | Both sample inputs carry a new sample |
| smp_left_i | input | SMP_W | Signed left sample |
| smp_right_i | input | SMP_W | Signed right sample |
| wr_en_i | input | 1 | One-cycle configuration write strobe |
| wr_data_i | input | 14 | Configuration word (fields in R2) |
| hw_mute_ni | input | 1 | Asynchronous hardware mute, active low |
| mute_left_o | output | 1 | Left channel muted |
| mute_right_o | output | 1 | Right channel muted |
| all_muted_no | output | 1 | Low when both channels are muted |

## Verification
The bench arms a mute and feeds each channel its own crossing in a different cycle. A design that shared one detector between the channels would switch both channels together. The bench repeats a write after feeding samples that never cross zero. A design that ignored the repeat, or treated every write as a repeat, would either stay armed or switch on the first write. It also lands a write on the same cycle as a crossing and holds samples with the valid strobe low. A design that let the stale crossing complete the change, or that tracked invalid samples, would switch early. The hardware pin is checked one and two edges after each change, and again after a write made during the hold. A latched pin or a missing synchronizer would show the wrong output at one of those samples.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
  localparam int NCH     = 2;
  localparam int CH_L    = 0;
  localparam int CH_R    = 1;
  localparam int ATT_W   = 6;
  localparam int ATT_MAX = 55;

  typedef struct packed {
    logic [ATT_W-1:0] att_r;
    logic [ATT_W-1:0] att_l;
    logic             zcm;
    logic             gmute;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RST = '{att_r: '0, att_l: '0, zcm: 1'b0, gmute: 1'b1};
endpackage

// File: rtl/zcm_sync.sv
module zcm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/zcm_channel.sv
module zcm_channel #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             wr_fire_i,
  input  logic             wr_gmute_i,
  input  logic             wr_zcm_i,
  input  logic             force_i,
  input  logic             held_gmute_i,
  output logic             sw_mute_o,
  output logic             pend_o,
  output logic             zc_o
);
  logic sw_q, sw_d;
  logic pend_q, pend_d;
  logic neg_q, neg_d;
  logic smp_neg;
  logic smp_zero;

  assign smp_neg  = smp_i[SMP_W-1];
  assign smp_zero = (smp_i == '0);
  assign zc_o     = smp_valid_i && (smp_zero || (smp_neg != neg_q));

  always_comb begin
    sw_d   = sw_q;
    pend_d = pend_q;
    neg_d  = neg_q;
    if (smp_valid_i) neg_d = smp_neg;
    if (wr_fire_i) begin
      if (!wr_zcm_i || force_i) begin
        sw_d   = wr_gmute_i;
        pend_d = 1'b0;
      end else begin
        pend_d = (wr_gmute_i != sw_q);
      end
    end else if (pend_q && zc_o) begin
      sw_d   = held_gmute_i;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b1;
      pend_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      sw_q   <= sw_d;
      pend_q <= pend_d;
      neg_q  <= neg_d;
    end
  end

  assign sw_mute_o = sw_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/zc_mute_ctrl.sv
module zc_mute_ctrl
  import zcm_pkg::*;
#(
  parameter int SMP_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             hw_mute_ni,
  output logic             mute_left_o,
  output logic             mute_right_o,
  output logic             all_muted_no
);
  logic rst_n;
  logic hw_n_s;

  zcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_n)
  );

  zcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) pin_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (hw_mute_ni),
    .q_o    (hw_n_s)
  );

  cfg_t cfg_q;
  cfg_t wr_cfg;
  logic rpt;

  logic [NCH-1:0]   sw_q;
  logic [NCH-1:0]   pend_q;
  logic [NCH-1:0]   zc;
  logic [NCH-1:0]   att_mute;
  logic [NCH-1:0]   mute;
  logic [SMP_W-1:0] smp [NCH];
  logic [ATT_W-1:0] att [NCH];

  assign wr_cfg = cfg_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RST;
    else if (wr_en_i) cfg_q <= wr_cfg;
  end

  assign rpt = wr_en_i && (wr_cfg == cfg_q) && (|pend_q);

  assign smp[CH_L] = smp_left_i;
  assign smp[CH_R] = smp_right_i;
  assign att[CH_L] = cfg_q.att_l;
  assign att[CH_R] = cfg_q.att_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zcm_channel #(.SMP_W(SMP_W)) ch_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_n),
      .smp_valid_i  (smp_valid_i),
      .smp_i        (smp[c]),
      .wr_fire_i    (wr_en_i),
      .wr_gmute_i   (wr_cfg.gmute),
      .wr_zcm_i     (wr_cfg.zcm),
      .force_i      (rpt),
      .held_gmute_i (cfg_q.gmute),
      .sw_mute_o    (sw_q[c]),
      .pend_o       (pend_q[c]),
      .zc_o         (zc[c])
    );
    assign att_mute[c] = (att[c] > ATT_W'(ATT_MAX));
    assign mute[c]     = !hw_n_s || att_mute[c] || sw_q[c];
  end

  assign mute_left_o  = mute[CH_L];
  assign mute_right_o = mute[CH_R];
  assign all_muted_no = !(&mute);
endmodule

// File: rtl/zcm_mute_chk.sv
module zcm_mute_chk
  import zcm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n,
  input logic             hw_mute_ni,
  input logic             wr_en_i,
  input logic [CFG_W-1:0] wr_data_i,
  input logic             mute_left_o,
  input logic             mute_right_o,
  input logic             all_muted_no,
  input logic [NCH-1:0]   sw_q,
  input logic [NCH-1:0]   pend_q,
  input logic [NCH-1:0]   zc,
  input logic             rpt
);
  logic [1:0] alive;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)              alive <= 2'd0;
    else if (alive != 2'd3)  alive <= alive + 2'd1;
  end

  assert_pin_mutes_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive == 2'd3 && !$past(hw_mute_ni, 2)) |-> (mute_left_o && mute_right_o));

  assert_flag_low_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !all_muted_no |-> (mute_left_o && mute_right_o));

  assert_direct_mute_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[1] && wr_data_i[0]) |=> (mute_left_o && mute_right_o));

  assert_att_mute_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && (wr_data_i[7:2] > ATT_W'(ATT_MAX))) |=> mute_left_o);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_wait_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      (pend_q[c] && !zc[c] && !wr_en_i) |=> $stable(sw_q[c]));

    assert_arm_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      (wr_en_i && wr_data_i[1] && !rpt && (wr_data_i[0] != sw_q[c])) |=> pend_q[c]);

    assert_repeat_forces_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
      rpt |=> (!pend_q[c] && (sw_q[c] == $past(wr_data_i[0]))));
  end
endmodule

bind zc_mute_ctrl zcm_mute_chk chk_i (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .hw_mute_ni   (hw_mute_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .mute_left_o  (mute_left_o),
  .mute_right_o (mute_right_o),
  .all_muted_no (all_muted_no),
  .sw_q         (sw_q),
  .pend_q       (pend_q),
  .zc           (zc),
  .rpt          (rpt)
);

// File: tb/zc_mute_ctrl_tb_top.sv
`timescale 1ns/1ps
module zc_mute_ctrl_tb_top;
  import zcm_pkg::*;

  localparam int SW = 16;

  logic          clk;
  logic          rst_n;
  logic          valid;
  logic [SW-1:0] sl, sr;
  logic          wr_en;
  logic [CFG_W-1:0] wr_data;
  logic          hw_n;
  logic          ml, mr, flag_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  zc_mute_ctrl #(.SMP_W(SW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .smp_valid_i  (valid),
    .smp_left_i   (sl),
    .smp_right_i  (sr),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .hw_mute_ni   (hw_n),
    .mute_left_o  (ml),
    .mute_right_o (mr),
    .all_muted_no (flag_n)
  );

  function automatic logic [CFG_W-1:0] wd(input logic gm, input logic zm,
                                          input int al, input int ar);
    return {ATT_W'(ar), ATT_W'(al), zm, gm};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic el, input logic er);
    logic ef;
    ef = !(el && er);
    total++;
    if (ml !== el || mr !== er || flag_n !== ef) begin
      bad++;
      $display("FAIL %s: got left=%0b right=%0b flag_n=%0b, expected left=%0b right=%0b flag_n=%0b",
               req, ml, mr, flag_n, el, er, ef);
    end
  endtask

  task automatic wr(input logic [CFG_W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic feed(input int l, input int r);
    valid = 1'b1; sl = SW'(l); sr = SW'(r);
    step();
    valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", 1'b1, 1'b1);
  endtask

  task automatic t_direct();
    wr(wd(1'b0, 1'b0, 0, 0));
    chk("R2 immediate unmute", 1'b0, 1'b0);
  endtask

  task automatic t_zc_mute();
    feed(100, 100);
    wr(wd(1'b1, 1'b1, 0, 0));
    chk("R3 armed mute waits", 1'b0, 1'b0);
    feed(50, 50);
    chk("R3 no crossing no switch", 1'b0, 1'b0);
    feed(-20, 30);
    chk("R5 left switches alone", 1'b1, 1'b0);
    feed(-10, 0);
    chk("R4 zero sample is a crossing", 1'b1, 1'b1);
  endtask

  task automatic t_repeat();
    wr(wd(1'b0, 1'b1, 0, 0));
    chk("R3 armed unmute waits", 1'b1, 1'b1);
    feed(-5, 7);
    chk("R4 same sign no crossing", 1'b1, 1'b1);
    wr(wd(1'b0, 1'b1, 0, 0));
    chk("R6 repeat write forces", 1'b0, 1'b0);
  endtask

  task automatic t_cancel();
    wr(wd(1'b1, 1'b1, 0, 0));
    chk("R3 armed again", 1'b0, 1'b0);
    wr(wd(1'b0, 1'b1, 0, 0));
    feed(5, -5);
    chk("R7 cancelled change ignores crossing", 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    wr_en = 1'b1; wr_data = wd(1'b1, 1'b1, 0, 0);
    valid = 1'b1; sl = SW'(-1); sr = SW'(1);
    step();
    wr_en = 1'b0; valid = 1'b0;
    chk("R12 crossing with write ignored", 1'b0, 1'b0);
    sl = SW'(9); sr = SW'(-9);
    step();
    chk("R4 invalid samples ignored", 1'b0, 1'b0);
    feed(-2, 2);
    chk("R4 tracked sign no crossing", 1'b0, 1'b0);
    feed(0, 0);
    chk("R3 switch on crossing", 1'b1, 1'b1);
  endtask

  task automatic t_hw();
    wr(wd(1'b0, 1'b0, 0, 0));
    chk("R2 unmute before pin test", 1'b0, 1'b0);
    hw_n = 1'b0;
    step();
    chk("R8 synchronizer delay", 1'b0, 1'b0);
    step();
    chk("R8 pin mutes both", 1'b1, 1'b1);
    hw_n = 1'b1;
    step();
    chk("R9 release delay", 1'b1, 1'b1);
    step();
    chk("R9 release restores unmuted", 1'b0, 1'b0);
    hw_n = 1'b0;
    step(); step();
    chk("R8 pin mutes again", 1'b1, 1'b1);
    wr(wd(1'b1, 1'b0, 0, 0));
    hw_n = 1'b1;
    step(); step();
    chk("R9 register mute survives release", 1'b1, 1'b1);
  endtask

  task automatic t_att();
    wr(wd(1'b0, 1'b0, 56, 55));
    chk("R11 code 56 mutes, 55 does not", 1'b1, 1'b0);
    wr(wd(1'b0, 1'b1, 63, 63));
    chk("R11 mute code immediate in zc mode", 1'b1, 1'b1);
    wr(wd(1'b0, 1'b1, 0, 0));
    chk("R10 flag high after attenuation cleared", 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; valid = 1'b0; sl = '0; sr = '0;
    wr_en = 1'b0; wr_data = '0; hw_n = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_direct();
    t_zc_mute();
    t_repeat();
    t_cancel();
    t_same_cycle();
    t_hw();
    t_att();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule